// File: doc/BRIEF.md
# Multi-Speed Ethernet MAC Clock Mode Generator

This block produces the three clocks a multi-speed Ethernet MAC needs: a MAC transmit clock, a MAC receive clock and a transmit clock sent toward the PHY. Its inputs are a free-running 250 MHz reference and two clocks that come in from the PHY side. A 2-bit interface selector (GMII, RGMII, an unsupported reduced-pin option, and a reset/default setting) and a 3-bit link-speed code pick, for each output, either a divided copy of the reference (by 2, 10 or 100) or one of the PHY clocks. Combinations the MAC cannot run are flagged, and the clocks fall back to the default setting.

All logic is clocked by the reference. The PHY clocks are resampled into the reference domain, so they must run well below the reference rate. The select code passes through a register pipeline. Each output has its own switch that moves from one source to another without producing a short pulse: it parks the output low on the old source's falling edge and re-enables it only after the new source has fallen.

Top module: `mac_clk_mode_gen`

## Requirements
- R1: The internal dividers produce 50% duty waveforms that start low after reset and toggle every 1, 5 and 50 reference cycles. These give the reference divided by 2, 10 and 100.
- R2: Interface code 2'b11 is the default setting for every speed code. Both MAC clocks run from the reference/2 divider, the PHY-facing clock is held low, and mode_error is 0.
- R3: Interface code 2'b00 (GMII) with speed code 3'b011 gives transmit = reference/2 and receive = PHY receive clock. The PHY-facing output copies the transmit clock.
- R4: GMII with speed code 3'b010, 3'b100 or 3'b111 takes transmit from the PHY transmit clock and receive from the PHY receive clock. The PHY-facing output copies the transmit clock for 3'b100 and 3'b111, and is held low for 3'b010.
- R5: Interface code 2'b01 (RGMII) gives transmit = reference/2 for 3'b011, reference/10 for 3'b100 and reference/100 for 3'b111. Receive is the PHY receive clock, and the PHY-facing output copies the transmit clock.
- R6: The following codes set mode_error to 1 and produce exactly the R2 clock configuration: interface 2'b10 with any speed; GMII with 3'b000, 3'b001, 3'b101 or 3'b110; RGMII with 3'b000, 3'b001, 3'b010, 3'b101 or 3'b110.
- R7: The select inputs pass through two register stages. mode_error after reference edge n reflects the code that was present at edge n-1.
- R8: When its source changes, an output is held low for the cycle in which the new source takes effect. No high or low phase of an output is shorter than the shorter half period of its old and new sources.
- R9: A synchronous active-low reset clears the dividers, synchronisers and outputs to 0 and loads the default code into the select pipeline.
- R10: In steady state, an output fed by a divider after edge n equals that divider's value before edge n. An output fed by a PHY clock after edge n equals that PHY input as sampled at edge n-2, after two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 250 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_sel | input | 2 | Interface code: 00 GMII, 01 RGMII, 10 unsupported, 11 default |
| speed_sel | input | 3 | Link-speed code |
| phy_tx_clk_i | input | 1 | Transmit clock supplied from the PHY side |
| phy_rx_clk_i | input | 1 | Receive clock supplied from the PHY side |
| mac_tx_clk | output | 1 | MAC transmit clock |
| mac_rx_clk | output | 1 | MAC receive clock |
| phy_tx_clk_o | output | 1 | Transmit clock sent to the PHY |
| mode_error | output | 1 | High while the registered code is unsupported |

## Verification
The bench builds the block with its default parameters: half periods of 1, 5 and 50 reference cycles, two select stages and two synchroniser stages. With these values, the reference/100 waveform completes several periods within one 600-cycle mode window, and the worst-case switchover, which drains a 50-cycle phase and then waits up to 100 cycles for the new source to fall, ends well inside the settle allowance. The PHY clocks are driven with half periods of 3 and 7 reference cycles. Because these are co-prime with the divider ratios, every switch between a PHY source and a divided source meets that source in many different phases.

// File: rtl/mac_clk_pkg.sv
// Shared types for the MAC clock mode generator.
// Assumes: source codes index an 8-entry source vector; unused codes read as 0.
package mac_clk_pkg;

    localparam int unsigned NUM_SRC = 8;
    localparam int unsigned CFG_W   = 5;

    typedef enum logic [2:0] {
        SRC_OFF    = 3'd0,
        SRC_DIV2   = 3'd1,
        SRC_DIV10  = 3'd2,
        SRC_DIV100 = 3'd3,
        SRC_PHY_TX = 3'd4,
        SRC_PHY_RX = 3'd5
    } clk_src_e;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_DRAIN = 2'd1,
        SW_ARM   = 2'd2
    } sw_state_e;

    typedef struct packed {
        clk_src_e tx;
        clk_src_e rx;
        logic     phy_en;
        logic     err;
    } route_t;

    localparam logic [1:0] IF_GMII  = 2'b00;
    localparam logic [1:0] IF_RGMII = 2'b01;
    localparam logic [1:0] IF_RMII  = 2'b10;
    localparam logic [1:0] IF_DFLT  = 2'b11;

    localparam logic [2:0] SPD_1G   = 3'b011;
    localparam logic [2:0] SPD_2G5  = 3'b010;
    localparam logic [2:0] SPD_100M = 3'b100;
    localparam logic [2:0] SPD_10M  = 3'b111;

    localparam logic [CFG_W-1:0] RESET_CFG = {IF_DFLT, 3'b000};

endpackage

// File: rtl/mac_clk_mode_decode.sv
// Combinational decode of interface/speed code into per-output clock routing.
// Assumes: the code comes from registers; unsupported codes get the default route plus err.
module mac_clk_mode_decode
    import mac_clk_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    output route_t           route
);

    logic [1:0] ifc;
    logic [2:0] spd;

    assign ifc = cfg[4:3];
    assign spd = cfg[2:0];

    // Table lookup: start from the default route, override for supported codes.
    always_comb begin
        route.tx     = SRC_DIV2;
        route.rx     = SRC_DIV2;
        route.phy_en = 1'b0;
        route.err    = 1'b0;
        unique case (ifc)
            IF_GMII: begin
                unique case (spd)
                    SPD_1G: begin
                        route.tx     = SRC_DIV2;
                        route.rx     = SRC_PHY_RX;
                        route.phy_en = 1'b1;
                    end
                    SPD_2G5: begin
                        route.tx     = SRC_PHY_TX;
                        route.rx     = SRC_PHY_RX;
                        route.phy_en = 1'b0;
                    end
                    SPD_100M, SPD_10M: begin
                        route.tx     = SRC_PHY_TX;
                        route.rx     = SRC_PHY_RX;
                        route.phy_en = 1'b1;
                    end
                    default: route.err = 1'b1;
                endcase
            end
            IF_RGMII: begin
                route.rx     = SRC_PHY_RX;
                route.phy_en = 1'b1;
                unique case (spd)
                    SPD_1G:   route.tx = SRC_DIV2;
                    SPD_100M: route.tx = SRC_DIV10;
                    SPD_10M:  route.tx = SRC_DIV100;
                    default: begin
                        route.tx     = SRC_DIV2;
                        route.rx     = SRC_DIV2;
                        route.phy_en = 1'b0;
                        route.err    = 1'b1;
                    end
                endcase
            end
            IF_RMII: route.err = 1'b1;
            default: route.err = 1'b0;
        endcase
    end

endmodule

// File: rtl/mac_clk_divider.sv
// Divides the reference by 2*HALF with 50% duty; output starts low after reset.
// Assumes: HALF >= 1; output is a register in the reference domain.
module mac_clk_divider #(
    parameter int unsigned HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_o
);

    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    // Count half-period cycles and flip the output at the end of each half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            div_o <= ~div_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mac_clk_sync.sv
// Resamples an asynchronous slow clock into the reference domain.
// Assumes: STAGES >= 2; the input runs far below the reference rate.
module mac_clk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] sh_q;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = sh_q[STAGES-1];

endmodule

// File: rtl/mac_clk_glitchless_sel.sv
// Switches one output between clock sources without runt pulses.
// On a request change it waits for the old source to be low and parks the
// output, then waits for a high-to-low step of the new source before enabling.
// Assumes: all sources are registers in the reference domain; SRC_OFF is constant 0.
module mac_clk_glitchless_sel
    import mac_clk_pkg::*;
#(
    parameter clk_src_e RESET_SRC = SRC_DIV2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_vec,
    input  clk_src_e           req,
    output logic               clk_o,
    output clk_src_e           cur_o
);

    sw_state_e st_q;
    clk_src_e  cur_q;
    clk_src_e  arm_q;
    logic      seen_hi_q;

    // Switch sequencer: run, drain the old source, arm on the new source's fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SW_RUN;
            cur_q     <= RESET_SRC;
            arm_q     <= RESET_SRC;
            seen_hi_q <= 1'b0;
            clk_o     <= 1'b0;
        end else begin
            unique case (st_q)
                SW_RUN: begin
                    clk_o <= src_vec[cur_q];
                    if (req != cur_q) begin
                        st_q <= SW_DRAIN;
                    end
                end
                SW_DRAIN: begin
                    if (!src_vec[cur_q]) begin
                        clk_o     <= 1'b0;
                        st_q      <= SW_ARM;
                        arm_q     <= req;
                        seen_hi_q <= 1'b0;
                    end else begin
                        clk_o <= src_vec[cur_q];
                    end
                end
                SW_ARM: begin
                    clk_o <= 1'b0;
                    if (req != arm_q) begin
                        arm_q     <= req;
                        seen_hi_q <= 1'b0;
                    end else if (req == SRC_OFF || (seen_hi_q && !src_vec[req])) begin
                        cur_q <= req;
                        st_q  <= SW_RUN;
                    end else if (src_vec[req]) begin
                        seen_hi_q <= 1'b1;
                    end
                end
                default: begin
                    st_q  <= SW_RUN;
                    clk_o <= 1'b0;
                end
            endcase
        end
    end

    assign cur_o = cur_q;

endmodule

// File: rtl/mac_clk_mode_gen.sv
// Top: registers the select code, decodes it, runs the dividers and
// synchronisers, and drives three glitch-free output switches.
// Assumes: every register is clocked by the 250 MHz reference; PHY clocks are slow.
module mac_clk_mode_gen
    import mac_clk_pkg::*;
#(
    parameter int unsigned DIV_FAST_HALF = 1,
    parameter int unsigned DIV_MID_HALF  = 5,
    parameter int unsigned DIV_SLOW_HALF = 50,
    parameter int unsigned SEL_STAGES    = 2,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic [1:0] if_sel,
    input  logic [2:0] speed_sel,
    input  logic       phy_tx_clk_i,
    input  logic       phy_rx_clk_i,
    output logic       mac_tx_clk,
    output logic       mac_rx_clk,
    output logic       phy_tx_clk_o,
    output logic       mode_error
);

    localparam int unsigned NUM_DIV = 3;
    localparam int unsigned NUM_PHY = 2;

    function automatic int unsigned div_half(input int unsigned idx);
        case (idx)
            0:       return DIV_FAST_HALF;
            1:       return DIV_MID_HALF;
            default: return DIV_SLOW_HALF;
        endcase
    endfunction

    logic [CFG_W-1:0]   cfg_pipe [SEL_STAGES];
    route_t             route;
    logic [NUM_DIV-1:0] div_clk;
    logic [NUM_PHY-1:0] phy_in;
    logic [NUM_PHY-1:0] phy_sync;
    logic [NUM_SRC-1:0] src_vec;
    clk_src_e           phy_req;
    clk_src_e           tx_cur;
    clk_src_e           rx_cur;
    clk_src_e           phy_cur;

    // Select pipeline: loads the default code in reset, then shifts the inputs in.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEL_STAGES; i++) begin
                cfg_pipe[i] <= RESET_CFG;
            end
        end else begin
            cfg_pipe[0] <= {if_sel, speed_sel};
            for (int i = 1; i < SEL_STAGES; i++) begin
                cfg_pipe[i] <= cfg_pipe[i-1];
            end
        end
    end

    mac_clk_mode_decode u_decode (
        .cfg   (cfg_pipe[SEL_STAGES-1]),
        .route (route)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_DIV; g++) begin : g_div
            mac_clk_divider #(
                .HALF (div_half(g))
            ) u_div (
                .clk   (ref_clk),
                .rst_n (rst_n),
                .div_o (div_clk[g])
            );
        end
    endgenerate

    assign phy_in = {phy_rx_clk_i, phy_tx_clk_i};

    generate
        for (g = 0; g < NUM_PHY; g++) begin : g_sync
            mac_clk_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk     (ref_clk),
                .rst_n   (rst_n),
                .async_i (phy_in[g]),
                .sync_o  (phy_sync[g])
            );
        end
    endgenerate

    // Gather all candidate sources into one vector indexed by source code.
    always_comb begin
        src_vec             = '0;
        src_vec[SRC_DIV2]   = div_clk[0];
        src_vec[SRC_DIV10]  = div_clk[1];
        src_vec[SRC_DIV100] = div_clk[2];
        src_vec[SRC_PHY_TX] = phy_sync[0];
        src_vec[SRC_PHY_RX] = phy_sync[1];
    end

    assign phy_req = route.phy_en ? route.tx : SRC_OFF;

    mac_clk_glitchless_sel #(
        .RESET_SRC (SRC_DIV2)
    ) u_sel_tx (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .src_vec (src_vec),
        .req     (route.tx),
        .clk_o   (mac_tx_clk),
        .cur_o   (tx_cur)
    );

    mac_clk_glitchless_sel #(
        .RESET_SRC (SRC_DIV2)
    ) u_sel_rx (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .src_vec (src_vec),
        .req     (route.rx),
        .clk_o   (mac_rx_clk),
        .cur_o   (rx_cur)
    );

    mac_clk_glitchless_sel #(
        .RESET_SRC (SRC_OFF)
    ) u_sel_phy (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .src_vec (src_vec),
        .req     (phy_req),
        .clk_o   (phy_tx_clk_o),
        .cur_o   (phy_cur)
    );

    assign mode_error = route.err;

endmodule

// File: rtl/mac_clk_mode_chk.sv
// Checker for the clock mode generator, bound to the top module.
// Assumes: the bench holds rst_n low for the first edges.
module mac_clk_mode_chk
    import mac_clk_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     div_fast,
    input clk_src_e tx_cur,
    input clk_src_e rx_cur,
    input clk_src_e phy_cur,
    input logic     mac_tx_clk,
    input logic     mac_rx_clk,
    input logic     phy_tx_clk_o,
    input logic     mode_error
);

    logic armed_q;

    // Marks that at least one reset edge has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end
    end

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!mac_tx_clk && !mac_rx_clk && !phy_tx_clk_o && !mode_error));

    a_r1_fast_div_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(rst_n)) |-> (div_fast != $past(div_fast)));

    a_r8_tx_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(rst_n) && tx_cur != $past(tx_cur)) |-> !mac_tx_clk);

    a_r8_rx_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(rst_n) && rx_cur != $past(rx_cur)) |-> !mac_rx_clk);

    a_r8_phy_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(rst_n) && phy_cur != $past(phy_cur)) |-> !phy_tx_clk_o);

    a_r4_phy_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && phy_cur == SRC_OFF) |-> !phy_tx_clk_o);

endmodule

bind mac_clk_mode_gen mac_clk_mode_chk u_chk (
    .clk          (ref_clk),
    .rst_n        (rst_n),
    .div_fast     (div_clk[0]),
    .tx_cur       (tx_cur),
    .rx_cur       (rx_cur),
    .phy_cur      (phy_cur),
    .mac_tx_clk   (mac_tx_clk),
    .mac_rx_clk   (mac_rx_clk),
    .phy_tx_clk_o (phy_tx_clk_o),
    .mode_error   (mode_error)
);

// File: tb/mac_clk_mode_gen_bench.sv
module mac_clk_mode_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] if_sel = 2'b11;
    logic [2:0] speed_sel = 3'b000;
    logic       ptx = 1'b0;
    logic       prx = 1'b0;
    logic       mac_tx_clk, mac_rx_clk, phy_tx_clk_o, mode_error;

    always #4 clk = ~clk;

    mac_clk_mode_gen u_mac_clk_mode_gen (
        .ref_clk      (clk),
        .rst_n        (rst_n),
        .if_sel       (if_sel),
        .speed_sel    (speed_sel),
        .phy_tx_clk_i (ptx),
        .phy_rx_clk_i (prx),
        .mac_tx_clk   (mac_tx_clk),
        .mac_rx_clk   (mac_rx_clk),
        .phy_tx_clk_o (phy_tx_clk_o),
        .mode_error   (mode_error)
    );

    // kinds: 0 off, 1 ref/2, 2 ref/10, 3 ref/100, 4 PHY tx, 5 PHY rx
    localparam int PTX_HALF = 3;
    localparam int PRX_HALF = 7;

    int    total = 0;
    int    bad = 0;
    int    n = 0;
    bit    rst_at_edge = 1'b0;
    bit    done = 1'b0;
    logic [4:0] h1 = 5'b11000;
    logic [4:0] h2 = 5'b11000;
    int    cur_k [3] = '{1, 1, 0};
    int    prev_k [3] = '{1, 1, 0};
    bit    exp_err = 1'b0;
    int    quiet = 0;
    string tag = "R2";
    int    run_len [3] = '{0, 0, 0};
    logic  last_v [3] = '{1'b0, 1'b0, 1'b0};
    bit    first_run [3] = '{1'b1, 1'b1, 1'b1};

    task automatic check(input bit ok, input string t, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", t, n, act, exp);
        end
    endtask

    // Behavioural table written from the requirements.
    task automatic model_route(input logic [4:0] c, output int t, output int r,
                               output int p, output bit e);
        t = 1; r = 1; p = 0; e = 1'b0;
        if (c[4:3] == 2'b00 && c[2:0] == 3'b011)      begin t = 1; r = 5; p = 1; end
        else if (c[4:3] == 2'b00 && c[2:0] == 3'b010) begin t = 4; r = 5; p = 0; end
        else if (c[4:3] == 2'b00 && (c[2:0] == 3'b100 || c[2:0] == 3'b111)) begin
            t = 4; r = 5; p = 4;
        end
        else if (c[4:3] == 2'b01 && c[2:0] == 3'b011) begin t = 1; r = 5; p = 1; end
        else if (c[4:3] == 2'b01 && c[2:0] == 3'b100) begin t = 2; r = 5; p = 2; end
        else if (c[4:3] == 2'b01 && c[2:0] == 3'b111) begin t = 3; r = 5; p = 3; end
        else if (c[4:3] == 2'b11) e = 1'b0;
        else e = 1'b1;
    endtask

    function automatic int half_of(input int k);
        case (k)
            1: return 1;
            2: return 5;
            3: return 50;
            4: return PTX_HALF;
            5: return PRX_HALF;
            default: return 0;
        endcase
    endfunction

    // Expected output value after edge m for a source kind.
    function automatic int expect_val(input int k, input int m);
        if (k == 0) return 0;
        if (k <= 3) return ((m - 1) / half_of(k)) % 2;
        return ((m - 2) / half_of(k)) % 2;
    endfunction

    // Model update on each reference edge.
    always @(posedge clk) begin
        int t, r, p;
        bit e;
        rst_at_edge = rst_n;
        if (!rst_n) begin
            n = 0;
            h1 = 5'b11000;
            h2 = 5'b11000;
        end else begin
            n = n + 1;
            h2 = h1;
            h1 = {if_sel, speed_sel};
        end
        model_route(h2, t, r, p, e);
        exp_err = e;
        if (!rst_n) begin
            cur_k = '{1, 1, 0};
            prev_k = '{1, 1, 0};
            quiet = 0;
            first_run = '{1'b1, 1'b1, 1'b1};
        end else if (t != cur_k[0] || r != cur_k[1] || p != cur_k[2]) begin
            prev_k = cur_k;
            cur_k = '{t, r, p};
            quiet = 220;
        end else if (quiet > 0) begin
            quiet = quiet - 1;
            if (quiet == 0) prev_k = cur_k;
        end
    end

    // Compare and drive PHY clocks away from the active edge.
    always @(negedge clk) begin
        logic outs [3];
        outs = '{mac_tx_clk, mac_rx_clk, phy_tx_clk_o};
        if (!rst_at_edge) begin
            check(!mac_tx_clk && !mac_rx_clk && !phy_tx_clk_o && !mode_error,
                  "R9 reset clears outputs",
                  {mac_tx_clk, mac_rx_clk, phy_tx_clk_o, mode_error}, 0);
            for (int i = 0; i < 3; i++) begin
                last_v[i] = 1'b0;
                run_len[i] = 0;
            end
        end else begin
            check(mode_error == exp_err, "R7 R6 mode_error", mode_error, exp_err);
            if (quiet == 0 && n >= 3) begin
                for (int i = 0; i < 3; i++) begin
                    int ev;
                    ev = expect_val(cur_k[i], n);
                    check(outs[i] == ev[0], {tag, " R10 output ", i == 0 ? "tx" : (i == 1 ? "rx" : "phy")},
                          outs[i], ev);
                end
            end
            for (int i = 0; i < 3; i++) begin
                if (outs[i] == last_v[i]) begin
                    run_len[i]++;
                end else begin
                    int a, b, lim;
                    a = half_of(prev_k[i]);
                    b = half_of(cur_k[i]);
                    lim = (a == 0) ? b : ((b == 0) ? a : ((a < b) ? a : b));
                    if (!first_run[i] && lim > 0)
                        check(run_len[i] >= lim, "R8 no runt pulse", run_len[i], lim);
                    first_run[i] = 1'b0;
                    last_v[i] = outs[i];
                    run_len[i] = 1;
                end
            end
        end
        ptx = (((n + 1) / PTX_HALF) % 2) != 0;
        prx = (((n + 1) / PRX_HALF) % 2) != 0;
    end

    task automatic run_mode(input logic [1:0] i_s, input logic [2:0] s_s,
                            input int cycles, input string t);
        @(negedge clk);
        if_sel = i_s;
        speed_sel = s_s;
        tag = t;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run_mode(2'b11, 3'b000, 500, "R2 R1");
        run_mode(2'b00, 3'b011, 600, "R3");
        run_mode(2'b00, 3'b010, 600, "R4");
        run_mode(2'b00, 3'b100, 600, "R4");
        run_mode(2'b00, 3'b111, 600, "R4");
        run_mode(2'b01, 3'b011, 600, "R5 R1");
        run_mode(2'b01, 3'b100, 600, "R5 R1");
        run_mode(2'b01, 3'b111, 600, "R5 R1");
        run_mode(2'b11, 3'b101, 500, "R2");
        for (int s = 0; s < 8; s++) run_mode(2'b10, 3'(s), 20, "R6");
        run_mode(2'b00, 3'b000, 20, "R6");
        run_mode(2'b00, 3'b001, 20, "R6");
        run_mode(2'b00, 3'b101, 20, "R6");
        run_mode(2'b00, 3'b110, 20, "R6");
        run_mode(2'b01, 3'b000, 20, "R6");
        run_mode(2'b01, 3'b001, 20, "R6");
        run_mode(2'b01, 3'b010, 20, "R6");
        run_mode(2'b01, 3'b101, 20, "R6");
        run_mode(2'b01, 3'b110, 20, "R6");
        run_mode(2'b01, 3'b111, 600, "R5");
        run_mode(2'b00, 3'b110, 500, "R6 R8");
        run_mode(2'b00, 3'b100, 600, "R4 R8");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (400) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule